// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Level Sequencer

This block produces the drive-level codes for a passive LCD panel run with 1/3 bias. It has four common outputs and fifty-three segment outputs. Each output is a 2-bit code that names one of four rails: ground, one third, two thirds or full supply. An analog stage outside the block turns each code into a voltage. A frame divider elsewhere supplies a slot-enable strobe. Each strobe moves the scan to the next common. A frame has two halves, and in each half every common is active once.

The block holds a display image of up to 208 pixels and a small set of mode fields. These are the commons count (four or three), full or reduced segment count, clock source, blanking and sleep. It decodes the image onto the pins for the selected commons count. It also applies the rules that force single pins, or the whole panel, to ground. New image and mode values are taken only at a frame wrap, so a frame is never drawn from a mix of old and new data. The enable input acts at once and is not held back until a frame wrap.

Top module: `lcdLevelSeq`

## Requirements
- R1: While rst_n is low the scan sits at common 0 in the first half. The captured image and modes are all zero (four commons, reduced segment count, internal clock, no blank, no sleep).
- R2: Each cycle with slotEn high advances the active common by one. After the last common (index 3, or 2 in three-common mode) the scan returns to common 0 and toggles the half. A frame is therefore 8 or 6 strobes.
- R3: Level codes are 0 for ground, 1 for one third, 2 for two thirds and 3 for full supply. With the panel driven, the active common is 3 in the first half and 0 in the second. Every other scanned common is 1 in the first half and 2 in the second.
- R4: A segment whose pixel for the active common is 1 outputs 0 in the first half and 3 in the second. A segment whose pixel is 0 outputs 2, then 1.
- R5: In four-common mode (cfgThreeCom=0), segment s (0-based) below 50 reads image bit 4s+k for active common k. Segment 51 reads bit 200+k and segment 52 reads bit 204+k.
- R6: In three-common mode, segment s reads image bit 3s+k with k in 0..2. Common 3 outputs 0.
- R7: In four-common mode segment 50 outputs 0.
- R8: With cfgFullSeg=0, segments 51 and 52 output 0.
- R9: With cfgExtClk=1, segment 52 outputs 0.
- R10: When inhibitN is low, or the captured sleep flag is 1, every common and segment outputs 0.
- R11: With the captured blank flag at 1 and the panel driven, the commons keep scanning and every segment follows the unlit pattern of R4.
- R12: pixelImage and the mode inputs are captured only on the strobe that ends the second half of a frame. They take effect from the next cycle on. Changes at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slotEn | input | 1 | Scan step strobe from the frame divider |
| inhibitN | input | 1 | Panel drive enable; low forces all outputs to ground |
| pixelImage | input | 208 | Display image, one bit per pixel |
| cfgThreeCom | input | 1 | 1 selects three-common multiplexing |
| cfgFullSeg | input | 1 | 1 enables the two highest segment pins |
| cfgExtClk | input | 1 | 1 marks the external clock source; grounds the top segment pin |
| cfgBlank | input | 1 | 1 drives unlit waveforms on all segments |
| cfgSleep | input | 1 | 1 grounds every output |
| comLevel | output | 8 | Level code of common k at bits 2k+1:2k |
| segLevel | output | 106 | Level code of segment s at bits 2s+1:2s |

## Verification
The critical coincidence is a frame wrap that lands in the same cycle as a change of image and modes, most sharply a switch between four and three commons. At the wrap edge the frame length itself changes, and the new pixel decode must start at once. The bench holds slotEn high and changes the inputs on the exact cycle of the wrap strobe, and also a few cycles before it. A cycle-level reference model then predicts when the new values appear. A second overlap is the enable pin falling during a wrap cycle. The outputs must go to ground at once, while the capture still takes place.

// File: rtl/lcdLevelPkg.sv
package lcdLevelPkg;

  localparam int COM_MAX   = 4;
  localparam int SEG_PINS  = 53;
  localparam int COM_IDX_W = $clog2(COM_MAX);

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } drvLevel_e;

  typedef struct packed {
    logic threeCom;
    logic fullSeg;
    logic extClk;
    logic blank;
    logic sleep;
  } modeCfg_t;

  typedef struct packed {
    logic                 loadFrame;
    logic                 secondHalf;
    logic [COM_IDX_W-1:0] activeCom;
  } scanStrobe_t;

endpackage

// File: rtl/lcdScanCtrl.sv
module lcdScanCtrl
  import lcdLevelPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slotEn,
  input  logic        frameThreeCom,
  output scanStrobe_t strobe
);

  logic [COM_IDX_W-1:0] comIdx;
  logic [COM_IDX_W-1:0] comLast;
  logic                 secondHalf;
  logic                 atLast;

  assign comLast = frameThreeCom ? COM_IDX_W'(COM_MAX - 2) : COM_IDX_W'(COM_MAX - 1);
  assign atLast  = slotEn && (comIdx == comLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comIdx     <= '0;
      secondHalf <= 1'b0;
    end else if (slotEn) begin
      if (comIdx == comLast) begin
        comIdx     <= '0;
        secondHalf <= !secondHalf;
      end else begin
        comIdx <= comIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadFrame  = atLast && secondHalf;
    strobe.secondHalf = secondHalf;
    strobe.activeCom  = comIdx;
  end

  // R2: the scan never runs past the last common of the current mode
  assert_com_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    comIdx <= comLast);

  // R2: a frame wrap restarts at common 0 in the first half
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadFrame |=> (comIdx == '0 && !secondHalf));

  // R2: without a strobe the scan position holds
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slotEn |=> ($stable(comIdx) && $stable(secondHalf)));

endmodule

// File: rtl/lcdLevelPath.sv
module lcdLevelPath
  import lcdLevelPkg::*;
#(
  parameter  int SEG_COUNT = SEG_PINS,
  parameter  int COM_COUNT = COM_MAX,
  localparam int IMG_BITS  = (SEG_COUNT - 1) * COM_COUNT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inhibitN,
  input  scanStrobe_t            strobe,
  input  logic [IMG_BITS-1:0]    pixelImage,
  input  modeCfg_t               cfgIn,
  output logic                   frameThreeCom,
  output logic [2*COM_COUNT-1:0] comLevel,
  output logic [2*SEG_COUNT-1:0] segLevel
);

  localparam int GAP_SEG = SEG_COUNT - 3;
  localparam int EXT_SEG = SEG_COUNT - 1;
  localparam int IDX_W   = $clog2(IMG_BITS);

  logic [IMG_BITS-1:0] shadowImg;
  modeCfg_t            cfgQ;
  logic                driveOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowImg <= '0;
      cfgQ      <= '0;
    end else if (strobe.loadFrame) begin
      shadowImg <= pixelImage;
      cfgQ      <= cfgIn;
    end
  end

  assign frameThreeCom = cfgQ.threeCom;
  assign driveOn       = inhibitN && !cfgQ.sleep;

  logic [COM_COUNT-1:0] comAtRail;

  for (genvar c = 0; c < COM_COUNT; c++) begin : g_com
    drvLevel_e lvl;
    always_comb begin
      if (!driveOn || (cfgQ.threeCom && c == COM_COUNT - 1)) begin
        lvl = LVL_GND;
      end else if (strobe.activeCom == COM_IDX_W'(c)) begin
        lvl = strobe.secondHalf ? LVL_GND : LVL_TOP;
      end else begin
        lvl = strobe.secondHalf ? LVL_HIGH : LVL_LOW;
      end
    end
    assign comLevel[2*c +: 2] = lvl;
    assign comAtRail[c] = comLevel[2*c+1] ~^ comLevel[2*c];
  end

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    localparam int BASE4 = (s < GAP_SEG) ? COM_COUNT * s : COM_COUNT * (s - 1);
    localparam int BASE3 = (COM_COUNT - 1) * s;
    logic [IDX_W-1:0] pick;
    logic             pinLit;
    logic             pinForced;
    drvLevel_e        lvl;
    always_comb begin
      if (cfgQ.threeCom) pick = IDX_W'(BASE3) + IDX_W'(strobe.activeCom);
      else               pick = IDX_W'(BASE4) + IDX_W'(strobe.activeCom);
      pinLit    = shadowImg[pick] && !cfgQ.blank;
      pinForced = !driveOn
               || (s == GAP_SEG && !cfgQ.threeCom)
               || (s >  GAP_SEG && !cfgQ.fullSeg)
               || (s == EXT_SEG && cfgQ.extClk);
      if (pinForced)   lvl = LVL_GND;
      else if (pinLit) lvl = strobe.secondHalf ? LVL_TOP : LVL_GND;
      else             lvl = strobe.secondHalf ? LVL_LOW : LVL_HIGH;
    end
    assign segLevel[2*s +: 2] = lvl;
  end

  // R12: captured image only moves on the frame-wrap strobe
  assert_hold_image_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadFrame |=> $stable(shadowImg) && $stable(cfgQ));

  // R10: a disabled panel shows ground on every pin
  assert_dark_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !driveOn |-> (comLevel == '0 && segLevel == '0));

  // R6: the fourth common idles at ground in three-common mode
  assert_com4_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfgQ.threeCom |-> comLevel[2*COM_COUNT-1 -: 2] == LVL_GND);

  // R7: the gap segment is grounded in four-common mode
  assert_gap_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgQ.threeCom |-> segLevel[2*GAP_SEG+1 -: 2] == LVL_GND);

  // R3: exactly one common sits on a rail while four commons scan
  assert_single_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (driveOn && !cfgQ.threeCom) |-> $countones(comAtRail) == 1);

endmodule

// File: rtl/lcdLevelSeq.sv
module lcdLevelSeq
  import lcdLevelPkg::*;
#(
  parameter  int SEG_COUNT = SEG_PINS,
  parameter  int COM_COUNT = COM_MAX,
  localparam int IMG_BITS  = (SEG_COUNT - 1) * COM_COUNT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   slotEn,
  input  logic                   inhibitN,
  input  logic [IMG_BITS-1:0]    pixelImage,
  input  logic                   cfgThreeCom,
  input  logic                   cfgFullSeg,
  input  logic                   cfgExtClk,
  input  logic                   cfgBlank,
  input  logic                   cfgSleep,
  output logic [2*COM_COUNT-1:0] comLevel,
  output logic [2*SEG_COUNT-1:0] segLevel
);

  scanStrobe_t strobe;
  modeCfg_t    cfgIn;
  logic        frameThreeCom;

  always_comb begin
    cfgIn.threeCom = cfgThreeCom;
    cfgIn.fullSeg  = cfgFullSeg;
    cfgIn.extClk   = cfgExtClk;
    cfgIn.blank    = cfgBlank;
    cfgIn.sleep    = cfgSleep;
  end

  lcdScanCtrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .slotEn        (slotEn),
    .frameThreeCom (frameThreeCom),
    .strobe        (strobe)
  );

  lcdLevelPath #(
    .SEG_COUNT (SEG_COUNT),
    .COM_COUNT (COM_COUNT)
  ) u_path (
    .clk           (clk),
    .rst_n         (rst_n),
    .inhibitN      (inhibitN),
    .strobe        (strobe),
    .pixelImage    (pixelImage),
    .cfgIn         (cfgIn),
    .frameThreeCom (frameThreeCom),
    .comLevel      (comLevel),
    .segLevel      (segLevel)
  );

endmodule

// File: tb/lcdLevelSeq_tb.sv
module lcdLevelSeq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 53;
  localparam int NCOM = 4;
  localparam int NIMG = 208;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            slotEn = 1'b0;
  logic            inhibitN = 1'b1;
  logic [NIMG-1:0] pixelImage = '0;
  logic            cfgThreeCom = 1'b0;
  logic            cfgFullSeg = 1'b1;
  logic            cfgExtClk = 1'b0;
  logic            cfgBlank = 1'b0;
  logic            cfgSleep = 1'b0;
  logic [2*NCOM-1:0] comLevel;
  logic [2*NSEG-1:0] segLevel;

  int vectors = 0;
  int miscompares = 0;
  bit inReset = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdLevelSeq u_dut (
    .clk(clk), .rst_n(rst_n), .slotEn(slotEn), .inhibitN(inhibitN),
    .pixelImage(pixelImage), .cfgThreeCom(cfgThreeCom), .cfgFullSeg(cfgFullSeg),
    .cfgExtClk(cfgExtClk), .cfgBlank(cfgBlank), .cfgSleep(cfgSleep),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  // Reference model state
  int mCom, mHalf;
  bit [NIMG-1:0] mImg;
  bit mThree, mFull, mExt, mBlank, mSleep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCom = 0; mHalf = 0; mImg = '0;
      mThree = 0; mFull = 0; mExt = 0; mBlank = 0; mSleep = 0;
    end else if (slotEn) begin
      if (mCom == (mThree ? 2 : 3)) begin
        mCom = 0;
        if (mHalf == 1) begin
          mHalf = 0;
          mImg = pixelImage; mThree = cfgThreeCom; mFull = cfgFullSeg;
          mExt = cfgExtClk; mBlank = cfgBlank; mSleep = cfgSleep;
        end else begin
          mHalf = 1;
        end
      end else begin
        mCom = mCom + 1;
      end
    end
  end

  function automatic bit panelOff();
    return !inhibitN || mSleep;
  endfunction

  function automatic int expCom(int c);
    if (panelOff()) return 0;
    if (mThree && c == 3) return 0;
    if (c == mCom) return mHalf ? 0 : 3;
    return mHalf ? 2 : 1;
  endfunction

  function automatic int expSeg(int s);
    int idx;
    bit lit;
    if (panelOff()) return 0;
    if (!mThree && s == 50) return 0;
    if (!mFull && s >= 51) return 0;
    if (mExt && s == 52) return 0;
    if (mThree) idx = 3*s + mCom;
    else if (s < 50) idx = 4*s + mCom;
    else if (s == 51) idx = 200 + mCom;
    else idx = 204 + mCom;
    lit = mBlank ? 1'b0 : mImg[idx];
    if (lit) return mHalf ? 3 : 0;
    return mHalf ? 1 : 2;
  endfunction

  function automatic string segTag(int s);
    if (inReset) return "R1";
    if (panelOff()) return "R10";
    if (!mThree && s == 50) return "R7";
    if (!mFull && s >= 51) return "R8";
    if (mExt && s == 52) return "R9";
    if (mBlank) return "R11";
    if (mThree) return "R6,R4,R12";
    return "R4,R5,R12";
  endfunction

  function automatic string comTag(int c);
    if (inReset) return "R1";
    if (panelOff()) return "R10";
    if (mThree && c == 3) return "R6";
    return "R2,R3";
  endfunction

  task automatic compareAll();
    vectors++;
    for (int c = 0; c < NCOM; c++) begin
      if (int'(comLevel[2*c +: 2]) != expCom(c)) begin
        miscompares++;
        $display("FAIL %s com %0d got %0d expected %0d at %0t", comTag(c), c,
                 comLevel[2*c +: 2], expCom(c), $time);
      end
    end
    for (int s = 0; s < NSEG; s++) begin
      if (int'(segLevel[2*s +: 2]) != expSeg(s)) begin
        miscompares++;
        $display("FAIL %s seg %0d got %0d expected %0d at %0t", segTag(s), s,
                 segLevel[2*s +: 2], expSeg(s), $time);
      end
    end
  endtask

  task automatic newImage();
    logic [223:0] wide;
    for (int w = 0; w < 7; w++) wide[w*32 +: 32] = $urandom;
    pixelImage = wide[NIMG-1:0];
  endtask

  // One cycle: check at the falling edge, then set inputs for the next edge
  task automatic step(input bit en);
    @(negedge clk);
    compareAll();
    slotEn = en;
  endtask

  // gap: slotEn every gap-th cycle; churn: new image every churn cycles
  task automatic run(input int n, input int gap, input int churn);
    for (int i = 0; i < n; i++) begin
      if (churn > 0 && (i % churn) == churn - 1) newImage();
      step((i % gap) == 0);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    inReset = 1'b0;
    newImage();
    // R2 R3 R4 R5 R12: four-common scan, image changing mid-frame
    run(64, 1, 5);
    // R12: hold image constant across frames, sparse strobes
    run(40, 3, 0);
    // R8: reduced segment count
    cfgFullSeg = 1'b0;
    run(40, 1, 7);
    // R9: external clock source
    cfgFullSeg = 1'b1;
    cfgExtClk = 1'b1;
    run(40, 1, 7);
    // R6 R7: three commons, gap pin driven
    cfgExtClk = 1'b0;
    cfgThreeCom = 1'b1;
    run(60, 2, 6);
    // R11: blanking keeps commons scanning
    cfgBlank = 1'b1;
    run(40, 1, 0);
    cfgBlank = 1'b0;
    // R10: sleep grounds everything
    cfgSleep = 1'b1;
    run(30, 1, 0);
    cfgSleep = 1'b0;
    run(20, 1, 0);
    // R10: inhibit acts at once, including across a wrap
    inhibitN = 1'b0;
    run(15, 1, 4);
    inhibitN = 1'b1;
    // R12 R6 R5: mode flip back to four commons with wrap coincidences
    cfgThreeCom = 1'b0;
    run(30, 1, 3);
    cfgThreeCom = 1'b1;
    run(30, 1, 2);
    cfgThreeCom = 1'b0;
    cfgExtClk = 1'b1;
    cfgFullSeg = 1'b0;
    run(40, 1, 9);
    step(1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule